// File: doc/BRIEF.md
# Channel Function Switch Sequencer

This block sits on the host side of a four-channel analog I/O converter and moves one channel safely from its present operating function to a new one. A request names a channel and a 4-bit function code. The sequencer then issues the register reads and writes that the change needs, over a read port and a write port. Both ports use a valid/ready handshake with an 8-bit address and 16-bit data. It inserts the required waits, counted on an external one-microsecond tick, and signals completion with a one-cycle pulse.

The order is fixed. The channel is parked in high impedance. Its DAC code is cleared and then latched with a command key. After a parking delay the new function is applied, and a settling delay follows before the caller may load a new DAC code. When the new function is the loop-powered current input (code 5), the channel's ADC configuration register also gets its pull-down bit set. The function field and the ADC configuration field are changed by read-modify-write, so the other bits of those registers survive.

A channel's function also has a minimum lifetime. Any two function-field writes on one channel are kept apart by at least a dwell time. While a sequence runs, further requests are refused with a one-cycle pulse and are dropped.

Top module: `chanfn_switch_seq`

## Requirements
- R1: After reset, `busy`, `done`, `start_refused`, `wr_valid` and `rd_valid` are all low.
- R2: The first write of a sequence goes to the function register at address 0x01 plus the channel index. Its bits 3:0 carry the high-impedance code 0. It follows a read of that same address.
- R3: The second write puts 0x0000 into the DAC code register at 0x16 plus the channel. The third write puts the latch key 0x953A into the command register at 0x44. Both come before the new function is written.
- R4: Both function writes keep bits 15:4 as they were read. The fourth write carries the requested code in bits 3:0.
- R5: The new-function write is accepted no sooner than PARK_US ticks after the latch-key write is accepted.
- R6: At least SETTLE_US ticks pass after the new-function write before `done` (or the ADC configuration write, where there is one).
- R7: For function code 5 only, the ADC configuration register at 0x05 plus the channel is read. It is then written back with bit 2 set and every other bit kept. For any other code, no fifth write is issued.
- R8: `done` is high for exactly one cycle per sequence. `busy` is high from the cycle after a request is accepted through the `done` cycle, and low afterwards.
- R9: A request that arrives while `busy` is high, including in the `done` cycle, raises `start_refused` for one cycle. It causes no register access.
- R10: Two function-field writes on the same channel, within one sequence or across sequences, are accepted at least DWELL_US ticks apart.
- R11: While `wr_valid` (or `rd_valid`) is high and not yet accepted, it stays high and its address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond, time base for all waits |
| start_valid | input | 1 | Request to switch a channel's function |
| start_chan | input | CH_W | Channel index of the request |
| start_func | input | 4 | New function code of the request |
| busy | output | 1 | A sequence is in progress |
| start_refused | output | 1 | One-cycle pulse: a request was dropped because the block was busy |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 8 | Write register address |
| wr_data | output | 16 | Write register data |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 8 | Read register address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 16 | Returned register value |

## Verification
The completion pulse and a new request can fall in the same cycle. In that cycle the block is still busy, so the request must be refused and not started. The bench waits until it sees `done` high and drives a request for another channel in that very cycle. It then judges the outcome by one refusal pulse, no further reads or writes over the following cycles, and an untouched function register on the second channel.

// File: rtl/chanfn_pkg.sv
package chanfn_pkg;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned FUNC_W = 4;

  localparam logic [ADDR_W-1:0] FUNC_BASE    = 8'h01;
  localparam logic [ADDR_W-1:0] ADCCFG_BASE  = 8'h05;
  localparam logic [ADDR_W-1:0] DACCODE_BASE = 8'h16;
  localparam logic [ADDR_W-1:0] CMDKEY_ADDR  = 8'h44;
  localparam logic [DATA_W-1:0] LATCH_KEY    = 16'h953A;
  localparam int unsigned       ADC_LOOP_BIT = 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_GATE_OLD,
    S_RD_FN,
    S_RSP_FN,
    S_WR_HIZ,
    S_WR_DAC,
    S_WR_KEY,
    S_PARK,
    S_WR_NEW,
    S_SETTLE,
    S_RD_ADC,
    S_RSP_ADC,
    S_WR_ADC,
    S_DONE
  } seq_state_e;

  // per-channel register address: bank base plus channel offset
  function automatic logic [ADDR_W-1:0] reg_of(input logic [ADDR_W-1:0] base,
                                               input logic [ADDR_W-1:0] ch);
    return base + ch;
  endfunction

  // replace only the function field, keep the upper bits
  function automatic logic [DATA_W-1:0] put_func(input logic [DATA_W-1:0] old,
                                                 input logic [FUNC_W-1:0] code);
    return {old[DATA_W-1:FUNC_W], code};
  endfunction

  // set the loop pull-down bit, keep the rest
  function automatic logic [DATA_W-1:0] set_loop_bit(input logic [DATA_W-1:0] old);
    return old | (DATA_W'(1) << ADC_LOOP_BIT);
  endfunction

endpackage

// File: rtl/chanfn_tick_timer.sv
module chanfn_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!run) begin
      count_q <= '0;
    end else if (tick && (count_q < limit)) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign expired = run && (count_q >= limit);

endmodule

// File: rtl/chanfn_dwell_track.sv
module chanfn_dwell_track #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned DWELL_US = 130,
  parameter int unsigned CH_W     = 2,
  localparam int unsigned AGE_W   = $clog2(DWELL_US + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fn_wr,
  input  logic [CH_W-1:0]   fn_wr_ch,
  output logic [NUM_CH-1:0] settled
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age_q <= AGE_W'(DWELL_US);
      end else if (fn_wr && (fn_wr_ch == CH_W'(g))) begin
        age_q <= '0;
      end else if (tick && (age_q < AGE_W'(DWELL_US))) begin
        age_q <= age_q + AGE_W'(1);
      end
    end

    assign settled[g] = (age_q >= AGE_W'(DWELL_US));
  end

endmodule

// File: rtl/chanfn_step_decode.sv
module chanfn_step_decode
  import chanfn_pkg::*;
#(
  parameter int unsigned      CH_W     = 2,
  parameter logic [FUNC_W-1:0] HIZ_CODE = 4'd0
) (
  input  seq_state_e        state,
  input  logic [CH_W-1:0]   ch,
  input  logic [FUNC_W-1:0] func,
  input  logic [DATA_W-1:0] fn_shadow,
  input  logic [DATA_W-1:0] adc_shadow,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              req_is_wr,
  output logic              req_is_rd
);

  logic [ADDR_W-1:0] ch_off;
  assign ch_off = ADDR_W'(ch);

  always_comb begin
    req_addr  = '0;
    req_data  = '0;
    req_is_wr = 1'b0;
    req_is_rd = 1'b0;
    case (state)
      S_RD_FN: begin
        req_is_rd = 1'b1;
        req_addr  = reg_of(FUNC_BASE, ch_off);
      end
      S_WR_HIZ: begin
        req_is_wr = 1'b1;
        req_addr  = reg_of(FUNC_BASE, ch_off);
        req_data  = put_func(fn_shadow, HIZ_CODE);
      end
      S_WR_DAC: begin
        req_is_wr = 1'b1;
        req_addr  = reg_of(DACCODE_BASE, ch_off);
        req_data  = '0;
      end
      S_WR_KEY: begin
        req_is_wr = 1'b1;
        req_addr  = CMDKEY_ADDR;
        req_data  = LATCH_KEY;
      end
      S_WR_NEW: begin
        req_is_wr = 1'b1;
        req_addr  = reg_of(FUNC_BASE, ch_off);
        req_data  = put_func(fn_shadow, func);
      end
      S_RD_ADC: begin
        req_is_rd = 1'b1;
        req_addr  = reg_of(ADCCFG_BASE, ch_off);
      end
      S_WR_ADC: begin
        req_is_wr = 1'b1;
        req_addr  = reg_of(ADCCFG_BASE, ch_off);
        req_data  = set_loop_bit(adc_shadow);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/chanfn_switch_seq.sv
module chanfn_switch_seq
  import chanfn_pkg::*;
#(
  parameter int unsigned       NUM_CH        = 4,
  parameter int unsigned       PARK_US       = 130,
  parameter int unsigned       SETTLE_US     = 150,
  parameter int unsigned       DWELL_US      = 130,
  parameter logic [FUNC_W-1:0] HIZ_CODE      = 4'd0,
  parameter logic [FUNC_W-1:0] LOOP_CUR_CODE = 4'd5,
  localparam int unsigned      CH_W          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned      TMR_MAX       = (PARK_US > SETTLE_US) ? PARK_US : SETTLE_US,
  localparam int unsigned      TMR_W         = $clog2(TMR_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              start_valid,
  input  logic [CH_W-1:0]   start_chan,
  input  logic [FUNC_W-1:0] start_func,
  output logic              busy,
  output logic              start_refused,
  output logic              done,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data
);

  seq_state_e        state_q, state_d;
  logic [CH_W-1:0]   ch_q;
  logic [FUNC_W-1:0] func_q;
  logic [DATA_W-1:0] fn_shadow_q;
  logic [DATA_W-1:0] adc_shadow_q;
  logic              refused_q;

  // named internal events
  logic accept_evt;
  logic wr_fire;
  logic fn_wr_evt;
  logic fn_new_evt;
  logic latch_evt;
  logic timer_run;
  logic timer_expired;
  logic ch_settled;
  logic is_loop;
  logic [TMR_W-1:0]  timer_limit;
  logic [NUM_CH-1:0] settled_vec;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic              req_is_wr;
  logic              req_is_rd;

  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_DONE);
  assign accept_evt = start_valid && (state_q == S_IDLE);
  assign wr_fire    = wr_valid && wr_ready;
  assign fn_wr_evt  = wr_fire && ((state_q == S_WR_HIZ) || (state_q == S_WR_NEW));
  assign fn_new_evt = wr_fire && (state_q == S_WR_NEW);
  assign latch_evt  = wr_fire && (state_q == S_WR_KEY);
  assign is_loop    = (func_q == LOOP_CUR_CODE);
  assign ch_settled = settled_vec[ch_q];

  assign timer_run   = (state_q == S_PARK) || (state_q == S_SETTLE);
  assign timer_limit = (state_q == S_SETTLE) ? TMR_W'(SETTLE_US) : TMR_W'(PARK_US);

  chanfn_tick_timer #(
    .CNT_W (TMR_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timer_run),
    .tick    (us_tick),
    .limit   (timer_limit),
    .expired (timer_expired)
  );

  chanfn_dwell_track #(
    .NUM_CH   (NUM_CH),
    .DWELL_US (DWELL_US),
    .CH_W     (CH_W)
  ) u_dwell (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .fn_wr    (fn_wr_evt),
    .fn_wr_ch (ch_q),
    .settled  (settled_vec)
  );

  chanfn_step_decode #(
    .CH_W     (CH_W),
    .HIZ_CODE (HIZ_CODE)
  ) u_decode (
    .state      (state_q),
    .ch         (ch_q),
    .func       (func_q),
    .fn_shadow  (fn_shadow_q),
    .adc_shadow (adc_shadow_q),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_is_wr  (req_is_wr),
    .req_is_rd  (req_is_rd)
  );

  assign wr_valid      = req_is_wr;
  assign wr_addr       = req_addr;
  assign wr_data       = req_data;
  assign rd_valid      = req_is_rd;
  assign rd_addr       = req_addr;
  assign start_refused = refused_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (start_valid)  state_d = S_GATE_OLD;
      S_GATE_OLD: if (ch_settled)   state_d = S_RD_FN;
      S_RD_FN:    if (rd_ready)     state_d = S_RSP_FN;
      S_RSP_FN:   if (rd_rsp_valid) state_d = S_WR_HIZ;
      S_WR_HIZ:   if (wr_ready)     state_d = S_WR_DAC;
      S_WR_DAC:   if (wr_ready)     state_d = S_WR_KEY;
      S_WR_KEY:   if (wr_ready)     state_d = S_PARK;
      S_PARK:     if (timer_expired && ch_settled) state_d = S_WR_NEW;
      S_WR_NEW:   if (wr_ready)     state_d = S_SETTLE;
      S_SETTLE:   if (timer_expired) state_d = is_loop ? S_RD_ADC : S_DONE;
      S_RD_ADC:   if (rd_ready)     state_d = S_RSP_ADC;
      S_RSP_ADC:  if (rd_rsp_valid) state_d = S_WR_ADC;
      S_WR_ADC:   if (wr_ready)     state_d = S_DONE;
      S_DONE:                       state_d = S_IDLE;
      default:                      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      ch_q         <= '0;
      func_q       <= '0;
      fn_shadow_q  <= '0;
      adc_shadow_q <= '0;
      refused_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      refused_q <= start_valid && busy;
      if (accept_evt) begin
        ch_q   <= start_chan;
        func_q <= start_func;
      end
      if ((state_q == S_RSP_FN) && rd_rsp_valid) fn_shadow_q <= rd_rsp_data;
      if ((state_q == S_RSP_ADC) && rd_rsp_valid) adc_shadow_q <= rd_rsp_data;
    end
  end

endmodule

// File: rtl/chanfn_seq_checker.sv
module chanfn_seq_checker #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned PARK_US  = 130,
  parameter int unsigned DWELL_US = 130,
  parameter int unsigned CH_W     = 2,
  localparam int unsigned PW      = $clog2(PARK_US + 2),
  localparam int unsigned DW      = $clog2(DWELL_US + 2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            us_tick,
  input logic            start_valid,
  input logic            busy,
  input logic            done,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [7:0]      wr_addr,
  input logic [15:0]     wr_data,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [7:0]      rd_addr,
  input logic            fn_wr_evt,
  input logic            fn_new_evt,
  input logic            latch_evt,
  input logic [CH_W-1:0] ch_q
);

  logic [PW-1:0] park_cnt;
  logic [DW-1:0] age [NUM_CH];
  logic [DW-1:0] age_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      park_cnt <= PW'(PARK_US);
    end else if (latch_evt) begin
      park_cnt <= '0;
    end else if (us_tick && (park_cnt < PW'(PARK_US))) begin
      park_cnt <= park_cnt + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (!rst_n) begin
        age[i] <= DW'(DWELL_US);
      end else if (fn_wr_evt && (ch_q == CH_W'(i))) begin
        age[i] <= '0;
      end else if (us_tick && (age[i] < DW'(DWELL_US))) begin
        age[i] <= age[i] + DW'(1);
      end
    end
  end

  assign age_sel = age[ch_q];

  // R11
  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R11
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R8
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R8
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_valid));
  // R9
  p_refuse_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && start_valid |=> busy && $stable(ch_q));
  // R5
  p_park_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fn_new_evt |-> park_cnt >= PW'(PARK_US));
  // R10
  p_dwell_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fn_wr_evt |-> age_sel >= DW'(DWELL_US));
  // R11
  p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));

endmodule

bind chanfn_switch_seq chanfn_seq_checker #(
  .NUM_CH   (NUM_CH),
  .PARK_US  (PARK_US),
  .DWELL_US (DWELL_US),
  .CH_W     (CH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .us_tick     (us_tick),
  .start_valid (start_valid),
  .busy        (busy),
  .done        (done),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_addr     (rd_addr),
  .fn_wr_evt   (fn_wr_evt),
  .fn_new_evt  (fn_new_evt),
  .latch_evt   (latch_evt),
  .ch_q        (ch_q)
);

// File: tb/chanfn_switch_seq_tb.sv
module chanfn_switch_seq_tb;

  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned PARK     = 30;
  localparam int unsigned SETTLE   = 12;
  localparam int unsigned DWELL    = 40;
  localparam int unsigned TICK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        start_valid = 1'b0;
  logic [1:0]  start_chan = '0;
  logic [3:0]  start_func = '0;
  logic        busy, start_refused, done;
  logic        wr_valid, rd_valid;
  logic        wr_ready = 1'b0;
  logic        rd_ready = 1'b0;
  logic [7:0]  wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic        rd_rsp_valid = 1'b0;
  logic [15:0] rd_rsp_data = '0;

  always #2 clk = ~clk;

  chanfn_switch_seq #(
    .NUM_CH    (NUM_CH),
    .PARK_US   (PARK),
    .SETTLE_US (SETTLE),
    .DWELL_US  (DWELL)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .us_tick       (us_tick),
    .start_valid   (start_valid),
    .start_chan    (start_chan),
    .start_func    (start_func),
    .busy          (busy),
    .start_refused (start_refused),
    .done          (done),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_addr       (rd_addr),
    .rd_rsp_valid  (rd_rsp_valid),
    .rd_rsp_data   (rd_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] regs [0:255];
  logic [7:0]  log_addr [0:31];
  logic [15:0] log_data [0:31];
  int          log_t    [0:31];
  int          log_n = 0;
  int          tick_cum = 0;
  int          cyc = 0;
  int          done_cnt = 0;
  int          done_t = 0;
  int          refused_cnt = 0;
  int          hold_viol = 0;
  int          stall_seen = 0;
  int          rsp_delay = 0;
  logic [7:0]  rsp_addr = '0;
  logic        prev_wv = 1'b0;
  logic [7:0]  prev_wa = '0;
  logic [15:0] prev_wd = '0;
  int          last_fn_t [0:3];
  bit          fn_seen   [0:3];

  // register-file model; all stimulus set at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      us_tick = 1'b0;
      wr_ready = 1'b0;
      rd_ready = 1'b0;
      rd_rsp_valid = 1'b0;
    end else begin
      us_tick = ((cyc % TICK_DIV) == 0);
      if (us_tick) tick_cum++;
      wr_ready = ((cyc % 3) != 0);
      rd_ready = ((cyc % 2) == 0);
      rd_rsp_valid = 1'b0;
      if (rsp_delay > 0) begin
        rsp_delay--;
        if (rsp_delay == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data = regs[rsp_addr];
        end
      end
      if (prev_wv) begin
        if (!wr_valid || (wr_addr != prev_wa) || (wr_data != prev_wd)) hold_viol++;
        else stall_seen++;
      end
      prev_wv = wr_valid && !wr_ready;
      prev_wa = wr_addr;
      prev_wd = wr_data;
      if (wr_valid && wr_ready) begin
        if (log_n < 32) begin
          log_addr[log_n] = wr_addr;
          log_data[log_n] = wr_data;
          log_t[log_n] = tick_cum;
        end
        log_n++;
        if (wr_addr != 8'h44) regs[wr_addr] = wr_data;
      end
      if (rd_valid && rd_ready) begin
        rsp_delay = 2;
        rsp_addr = rd_addr;
      end
      if (done) begin
        done_cnt++;
        done_t = tick_cum;
      end
      if (start_refused) refused_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic start_req(input logic [1:0] ch, input logic [3:0] fn);
    @(negedge clk);
    start_valid = 1'b1;
    start_chan = ch;
    start_func = fn;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic verify_seq(input int ch, input logic [3:0] fn,
                            input logic [15:0] fn_pre, input logic [15:0] adc_pre);
    int exp_n;
    int t_end;
    bit loop;
    loop = (fn == 4'd5);
    exp_n = loop ? 5 : 4;
    chk(log_n == exp_n, "R7 write count", log_n, exp_n);
    chk(log_addr[0] == 8'(1 + ch) && log_data[0] == {fn_pre[15:4], 4'h0},
        "R2 park write", {log_addr[0], log_data[0]}, {8'(1 + ch), fn_pre[15:4], 4'h0});
    chk(log_addr[1] == 8'(8'h16 + ch) && log_data[1] == 16'h0000,
        "R3 dac zero", {log_addr[1], log_data[1]}, {8'(8'h16 + ch), 16'h0});
    chk(log_addr[2] == 8'h44 && log_data[2] == 16'h953A,
        "R3 latch key", {log_addr[2], log_data[2]}, {8'h44, 16'h953A});
    chk(log_addr[3] == 8'(1 + ch) && log_data[3] == {fn_pre[15:4], fn},
        "R4 new function", {log_addr[3], log_data[3]}, {8'(1 + ch), fn_pre[15:4], fn});
    chk((log_t[3] - log_t[2]) >= int'(PARK), "R5 park wait", log_t[3] - log_t[2], PARK);
    t_end = loop ? log_t[4] : done_t;
    chk((t_end - log_t[3]) >= int'(SETTLE), "R6 settle wait", t_end - log_t[3], SETTLE);
    if (loop) begin
      chk(log_addr[4] == 8'(5 + ch) && log_data[4] == (adc_pre | 16'h0004),
          "R7 adc bit", {log_addr[4], log_data[4]}, {8'(5 + ch), adc_pre | 16'h0004});
    end
    chk((log_t[3] - log_t[0]) >= int'(DWELL), "R10 dwell within", log_t[3] - log_t[0], DWELL);
    if (fn_seen[ch]) begin
      chk((log_t[0] - last_fn_t[ch]) >= int'(DWELL), "R10 dwell across",
          log_t[0] - last_fn_t[ch], DWELL);
    end
    last_fn_t[ch] = log_t[3];
    fn_seen[ch] = 1'b1;
  endtask

  task automatic run_switch(input int ch, input logic [3:0] fn);
    logic [15:0] fn_pre, adc_pre;
    int d0;
    fn_pre = regs[8'(1 + ch)];
    adc_pre = regs[8'(5 + ch)];
    d0 = done_cnt;
    log_n = 0;
    start_req(2'(ch), fn);
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R8 busy during run", busy, 1);
    wait_done();
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, "R8 single done pulse", done_cnt - d0, 1);
    chk(busy == 1'b0, "R8 idle after done", busy, 0);
    verify_seq(ch, fn, fn_pre, adc_pre);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && start_refused == 0 && wr_valid == 0 && rd_valid == 0,
        "R1 reset outputs", {busy, done, start_refused, wr_valid, rd_valid}, 0);
  endtask

  task automatic t_basic();
    run_switch(1, 4'd3);
  endtask

  task automatic t_loop();
    run_switch(2, 4'd5);
  endtask

  task automatic t_dwell_back_to_back();
    run_switch(2, 4'd7);
  endtask

  task automatic t_refuse_busy();
    int r0;
    logic [15:0] other;
    logic [15:0] fn_pre;
    r0 = refused_cnt;
    other = regs[8'h04];
    fn_pre = regs[8'h01];
    log_n = 0;
    start_req(2'd0, 4'd1);
    repeat (10) @(negedge clk);
    start_req(2'd3, 4'd9);
    wait_done();
    repeat (150) @(negedge clk);
    chk(refused_cnt == r0 + 1, "R9 refusal pulse", refused_cnt - r0, 1);
    chk(regs[8'h04] == other, "R9 refused channel untouched", regs[8'h04], other);
    verify_seq(0, 4'd1, fn_pre, 16'h0);
  endtask

  task automatic t_refuse_done_cycle();
    int r0;
    logic [15:0] other;
    logic [15:0] fn_pre;
    r0 = refused_cnt;
    other = regs[8'h02];
    fn_pre = regs[8'h04];
    log_n = 0;
    start_req(2'd3, 4'd2);
    wait_done();
    start_valid = 1'b1;
    start_chan = 2'd1;
    start_func = 4'd6;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (150) @(negedge clk);
    chk(refused_cnt == r0 + 1, "R9 refused in done cycle", refused_cnt - r0, 1);
    chk(busy == 1'b0, "R9 not started after done", busy, 0);
    chk(regs[8'h02] == other, "R9 done-cycle channel untouched", regs[8'h02], other);
    verify_seq(3, 4'd2, fn_pre, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 16'h0;
    for (int c = 0; c < 4; c++) begin
      regs[8'(1 + c)] = 16'hA5F2 ^ 16'(c << 8);
      regs[8'(5 + c)] = 16'h1231 + 16'(c << 8);
      fn_seen[c] = 1'b0;
      last_fn_t[c] = 0;
    end
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_loop();
    t_dwell_back_to_back();
    t_refuse_busy();
    t_refuse_done_cycle();
    chk(hold_viol == 0, "R11 held request changed", hold_viol, 0);
    chk(stall_seen > 0, "R11 stall exercised", stall_seen, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

endmodule